// File: doc/BRIEF.md
# Fetch-Set Line Fill Controller

This block refills a single 256-byte cache line held as sixteen 16-byte fetch sets. Each fetch set has its own valid and dirty flag, so a line can be partly present. A miss names the fetch set the core is waiting for, a region number and a prefetch flag. The controller first requests a read burst that starts exactly at that set. It raises a one-cycle done pulse as soon as that set has been written. If prefetch was asked for, it then keeps issuing bursts toward the end of the line. These bursts pass over sets that are already present, and they stop at the last set without wrapping.

Burst length is set per region by a 2-bit code on a configuration bus. No burst runs past the end of the line or into a set that is already valid, so a dirty set is never overwritten. A new miss can cut a running prefetch short, but only at a burst boundary. Sets already received stay valid. Write hits mark individual sets dirty, and a line clear empties the line between fills.

The read side is a master with two valid/ready channels. On the request channel (`rq_*`), once `rq_valid_o` is high it stays high, with start set and length unchanged, until the cycle in which `rq_ready_i` is seen. On the response channel (`rs_*`), one beat carries one fetch set in ascending order. The responder may stall by holding `rs_valid_i` low, and `rs_ready_o` is high for the whole data phase of a burst. The miss port is valid/ready as well: a request waits, unchanged, while `miss_ready_o` is low.

Top module: `lfill_line_ctrl`

## Requirements
- R1: After reset all valid and dirty flags are 0, `busy_o` and `rq_valid_o` are 0, and `miss_ready_o` is 1.
- R2: A miss is accepted whenever `miss_ready_o` is high in idle. The first burst it causes starts at the missed set. Region r takes its code from `cfg_burst_i[2r+1:2r]`, where code 0, 1, 2 or 3 gives 1, 2, 4 or 8 fetch sets. `rq_len_o` carries the beat count minus one.
- R3: Every burst is shortened so that it ends at set 15 at the latest, and it never reaches a set that is already valid.
- R4: `miss_done_o` is high for exactly one cycle. For a fetched set, that cycle is the one after its beat is accepted, and the set's valid flag is already high in it. A miss to a set that is already valid issues no request and still produces one done pulse.
- R5: With the prefetch flag set, bursts continue from the set after the previous burst. Valid sets are skipped, and fetching stops after set 15 without wrapping. With the flag clear, fetching stops after the first burst.
- R6: Beat k of a burst starting at set s writes set s+k. It drives `fill_wr_o`, `fill_set_o` = s+k and `fill_data_o` equal to the beat data in the same cycle. From the next cycle the set is valid and clean.
- R7: While busy, `miss_ready_o` is high only in a cycle in which the last beat of a burst is accepted. A miss accepted there drops the remaining prefetch, its own burst is next, and every set already received stays valid.
- R8: A write hit sets the dirty flag of the named set only, and only if that set is valid. A write hit to an invalid set changes nothing.
- R9: A line clear while idle makes every valid and dirty flag 0 from the next cycle. A line clear while busy is ignored.
- R10: A request held without `rq_ready_i` keeps `rq_valid_o`, `rq_set_o` and `rq_len_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| miss_valid_i | input | 1 | Miss request valid |
| miss_ready_o | output | 1 | Miss request accepted this cycle when valid |
| miss_set_i | input | 4 | Fetch set that missed |
| miss_region_i | input | 2 | Region selecting the burst code |
| miss_pf_i | input | 1 | Prefetch to end of line after the first burst |
| miss_done_o | output | 1 | One-cycle pulse: missed set now valid |
| cfg_burst_i | input | 8 | Per-region 2-bit burst codes |
| rq_valid_o | output | 1 | Burst request valid |
| rq_ready_i | input | 1 | Burst request taken |
| rq_set_o | output | 4 | First fetch set of the burst |
| rq_len_o | output | 3 | Beats in the burst minus one |
| rs_valid_i | input | 1 | Response beat valid |
| rs_ready_o | output | 1 | Controller accepts beats |
| rs_data_i | input | 128 | Beat data, one fetch set |
| fill_wr_o | output | 1 | Write one fetch set into the data store |
| fill_set_o | output | 4 | Fetch set being written |
| fill_data_o | output | 128 | Data being written |
| wr_hit_i | input | 1 | Core store hit |
| wr_set_i | input | 4 | Fetch set of the store |
| line_clr_i | input | 1 | Empty the line (idle only) |
| valid_o | output | 16 | Per-set valid flags |
| dirty_o | output | 16 | Per-set dirty flags |
| busy_o | output | 1 | A fill is in progress |

## Verification
The bench sweeps every missed set under every burst code, with prefetch both on and off. A design that ignores the end of the line would request past set 15. One that drops the clip would ask for a length the region does not give. One that signals done late or early would miss the exact cycle that is sampled. A partly filled line then checks that bursts stop short of valid sets and that prefetch skips them. A design with a wrapping or overwriting prefetch would issue a request the bench does not expect. A directed case raises a new miss in the middle of a prefetch burst. There `miss_ready_o` must stay low until the final beat, and the following request must belong to the new miss, not to the old prefetch. Dirty marking on an invalid set and a line clear issued while busy must both leave the flags unchanged.

// File: rtl/lfill_pkg.sv
package lfill_pkg;
  typedef enum logic [1:0] {
    FS_IDLE,
    FS_PLAN,
    FS_REQ,
    FS_DATA
  } fill_st_e;
endpackage

// File: rtl/lfill_scan.sv
// Finds the next absent fetch set at or above a cursor and the length of
// the burst that may start there: limited by the region code, the end of
// the line and the first set that is already present.
module lfill_scan #(
  parameter int N_SETS = 16,
  parameter int BCW    = 2,
  localparam int IW    = $clog2(N_SETS)
) (
  input  logic [N_SETS-1:0] valid_i,
  input  logic [IW:0]       from_i,
  input  logic [BCW-1:0]    code_i,
  output logic              found_o,
  output logic [IW-1:0]     first_o,
  output logic [IW:0]       beats_o
);
  int  cap;
  logic run;

  always_comb begin
    found_o = 1'b0;
    first_o = '0;
    for (int i = N_SETS - 1; i >= 0; i--) begin
      if (i >= int'(from_i) && !valid_i[i]) begin
        found_o = 1'b1;
        first_o = IW'(i);
      end
    end
  end

  always_comb begin
    cap     = 1 << code_i;
    run     = 1'b1;
    beats_o = '0;
    for (int i = 0; i < N_SETS; i++) begin
      if (i >= int'(first_o) && i < int'(first_o) + cap) begin
        if (run && !valid_i[i]) beats_o = beats_o + (IW+1)'(1);
        else                    run = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lfill_bits.sv
// Per-fetch-set valid and dirty flags.
module lfill_bits #(
  parameter int N_SETS = 16,
  localparam int IW    = $clog2(N_SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              fill_we_i,
  input  logic [IW-1:0]     fill_idx_i,
  input  logic              wr_i,
  input  logic [IW-1:0]     wr_idx_i,
  output logic [N_SETS-1:0] valid_o,
  output logic [N_SETS-1:0] dirty_o
);
  for (genvar g = 0; g < N_SETS; g++) begin : g_set
    logic v_q, d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (clr_i) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (fill_we_i && fill_idx_i == IW'(g)) begin
        v_q <= 1'b1;
        d_q <= 1'b0;
      end else if (wr_i && wr_idx_i == IW'(g) && v_q) begin
        d_q <= 1'b1;
      end
    end
    assign valid_o[g] = v_q;
    assign dirty_o[g] = d_q;
  end
endmodule

// File: rtl/lfill_ctrl.sv
// Sequencer: critical burst, optional prefetch bursts, boundary preemption.
module lfill_ctrl
  import lfill_pkg::*;
#(
  parameter int N_SETS    = 16,
  parameter int N_REGIONS = 4,
  parameter int BCW       = 2,
  localparam int IW       = $clog2(N_SETS),
  localparam int RW       = $clog2(N_REGIONS),
  localparam int LENW     = (1 << BCW) - 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   miss_valid_i,
  output logic                   miss_ready_o,
  input  logic [IW-1:0]          miss_set_i,
  input  logic [RW-1:0]          miss_region_i,
  input  logic                   miss_pf_i,
  output logic                   miss_done_o,
  input  logic [N_REGIONS*BCW-1:0] cfg_burst_i,
  input  logic [N_SETS-1:0]      valid_i,
  output logic [IW:0]            scan_from_o,
  output logic [BCW-1:0]         scan_code_o,
  input  logic                   scan_found_i,
  input  logic [IW-1:0]          scan_first_i,
  input  logic [IW:0]            scan_beats_i,
  output logic                   rq_valid_o,
  input  logic                   rq_ready_i,
  output logic [IW-1:0]          rq_set_o,
  output logic [LENW-1:0]        rq_len_o,
  input  logic                   rs_valid_i,
  output logic                   rs_ready_o,
  output logic                   fill_we_o,
  output logic [IW-1:0]          fill_idx_o,
  output logic                   busy_o
);
  fill_st_e       st_q;
  logic [IW:0]    cur_q;
  logic           crit_q, pf_q, done_q;
  logic [RW-1:0]  rg_q;
  logic [IW-1:0]  start_q;
  logic [IW:0]    beats_q, cnt_q, len_m1;
  logic           last_beat, miss_acc;

  assign scan_from_o = cur_q;
  assign scan_code_o = cfg_burst_i[rg_q*BCW +: BCW];

  assign len_m1      = beats_q - (IW+1)'(1);
  assign rq_valid_o  = (st_q == FS_REQ);
  assign rq_set_o    = start_q;
  assign rq_len_o    = len_m1[LENW-1:0];
  assign rs_ready_o  = (st_q == FS_DATA);
  assign fill_we_o   = rs_ready_o && rs_valid_i;
  assign fill_idx_o  = start_q + cnt_q[IW-1:0];
  assign last_beat   = fill_we_o && (cnt_q == len_m1);
  assign miss_ready_o = (st_q == FS_IDLE) || last_beat;
  assign miss_acc    = miss_valid_i && miss_ready_o;
  assign miss_done_o = done_q;
  assign busy_o      = (st_q != FS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FS_IDLE;
      cur_q   <= '0;
      crit_q  <= 1'b0;
      pf_q    <= 1'b0;
      done_q  <= 1'b0;
      rg_q    <= '0;
      start_q <= '0;
      beats_q <= '0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        FS_IDLE: begin
          if (miss_acc) begin
            cur_q  <= {1'b0, miss_set_i};
            crit_q <= 1'b1;
            pf_q   <= miss_pf_i;
            rg_q   <= miss_region_i;
            st_q   <= FS_PLAN;
          end
        end
        FS_PLAN: begin
          if (crit_q) begin
            if (valid_i[cur_q[IW-1:0]]) begin
              done_q <= 1'b1;
              crit_q <= 1'b0;
              cur_q  <= cur_q + (IW+1)'(1);
              st_q   <= pf_q ? FS_PLAN : FS_IDLE;
            end else begin
              start_q <= scan_first_i;
              beats_q <= scan_beats_i;
              st_q    <= FS_REQ;
            end
          end else if (pf_q && scan_found_i) begin
            start_q <= scan_first_i;
            beats_q <= scan_beats_i;
            st_q    <= FS_REQ;
          end else begin
            st_q <= FS_IDLE;
          end
        end
        FS_REQ: begin
          if (rq_ready_i) begin
            cnt_q <= '0;
            st_q  <= FS_DATA;
          end
        end
        FS_DATA: begin
          if (fill_we_o) begin
            cnt_q <= cnt_q + (IW+1)'(1);
            if (crit_q && fill_idx_o == cur_q[IW-1:0]) begin
              done_q <= 1'b1;
              crit_q <= 1'b0;
            end
            if (last_beat) begin
              cur_q <= {1'b0, start_q} + beats_q;
              st_q  <= FS_PLAN;
              if (miss_acc) begin
                cur_q  <= {1'b0, miss_set_i};
                crit_q <= 1'b1;
                pf_q   <= miss_pf_i;
                rg_q   <= miss_region_i;
              end
            end
          end
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lfill_line_ctrl.sv
module lfill_line_ctrl #(
  parameter int N_SETS    = 16,
  parameter int SET_BYTES = 16,
  parameter int N_REGIONS = 4,
  parameter int BCW       = 2,
  localparam int IW       = $clog2(N_SETS),
  localparam int RW       = $clog2(N_REGIONS),
  localparam int LENW     = (1 << BCW) - 1,
  localparam int DW       = SET_BYTES * 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     miss_valid_i,
  output logic                     miss_ready_o,
  input  logic [IW-1:0]            miss_set_i,
  input  logic [RW-1:0]            miss_region_i,
  input  logic                     miss_pf_i,
  output logic                     miss_done_o,
  input  logic [N_REGIONS*BCW-1:0] cfg_burst_i,
  output logic                     rq_valid_o,
  input  logic                     rq_ready_i,
  output logic [IW-1:0]            rq_set_o,
  output logic [LENW-1:0]          rq_len_o,
  input  logic                     rs_valid_i,
  output logic                     rs_ready_o,
  input  logic [DW-1:0]            rs_data_i,
  output logic                     fill_wr_o,
  output logic [IW-1:0]            fill_set_o,
  output logic [DW-1:0]            fill_data_o,
  input  logic                     wr_hit_i,
  input  logic [IW-1:0]            wr_set_i,
  input  logic                     line_clr_i,
  output logic [N_SETS-1:0]        valid_o,
  output logic [N_SETS-1:0]        dirty_o,
  output logic                     busy_o
);
  logic [IW:0]     scan_from, scan_beats;
  logic [BCW-1:0]  scan_code;
  logic            scan_found;
  logic [IW-1:0]   scan_first;

  assign fill_data_o = rs_data_i;

  lfill_scan #(.N_SETS(N_SETS), .BCW(BCW)) scan_i (
    .valid_i (valid_o),
    .from_i  (scan_from),
    .code_i  (scan_code),
    .found_o (scan_found),
    .first_o (scan_first),
    .beats_o (scan_beats)
  );

  lfill_bits #(.N_SETS(N_SETS)) bits_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (line_clr_i && !busy_o),
    .fill_we_i  (fill_wr_o),
    .fill_idx_i (fill_set_o),
    .wr_i       (wr_hit_i),
    .wr_idx_i   (wr_set_i),
    .valid_o    (valid_o),
    .dirty_o    (dirty_o)
  );

  lfill_ctrl #(.N_SETS(N_SETS), .N_REGIONS(N_REGIONS), .BCW(BCW)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid_i  (miss_valid_i),
    .miss_ready_o  (miss_ready_o),
    .miss_set_i    (miss_set_i),
    .miss_region_i (miss_region_i),
    .miss_pf_i     (miss_pf_i),
    .miss_done_o   (miss_done_o),
    .cfg_burst_i   (cfg_burst_i),
    .valid_i       (valid_o),
    .scan_from_o   (scan_from),
    .scan_code_o   (scan_code),
    .scan_found_i  (scan_found),
    .scan_first_i  (scan_first),
    .scan_beats_i  (scan_beats),
    .rq_valid_o    (rq_valid_o),
    .rq_ready_i    (rq_ready_i),
    .rq_set_o      (rq_set_o),
    .rq_len_o      (rq_len_o),
    .rs_valid_i    (rs_valid_i),
    .rs_ready_o    (rs_ready_o),
    .fill_we_o     (fill_wr_o),
    .fill_idx_o    (fill_set_o),
    .busy_o        (busy_o)
  );
endmodule

// File: rtl/lfill_line_ctrl_chk.sv
module lfill_line_ctrl_chk #(
  parameter int N_SETS = 16,
  parameter int LENW   = 3,
  localparam int IW    = $clog2(N_SETS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_ready_o,
  input logic              miss_done_o,
  input logic              rq_valid_o,
  input logic              rq_ready_i,
  input logic [IW-1:0]     rq_set_o,
  input logic [LENW-1:0]   rq_len_o,
  input logic              fill_wr_o,
  input logic [IW-1:0]     fill_set_o,
  input logic              line_clr_i,
  input logic [N_SETS-1:0] valid_o,
  input logic [N_SETS-1:0] dirty_o,
  input logic              busy_o
);
  a_r10_rq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid_o && !rq_ready_i |=> rq_valid_o && $stable(rq_set_o) && $stable(rq_len_o));

  a_r3_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid_o |-> (int'(rq_set_o) + int'(rq_len_o) < N_SETS));

  a_r3_start_absent: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid_o |-> !valid_o[rq_set_o]);

  a_r6_fill_absent: assert property (@(posedge clk) disable iff (!rst_n)
    fill_wr_o |-> !valid_o[fill_set_o]);

  a_r6_fill_marks: assert property (@(posedge clk) disable iff (!rst_n)
    fill_wr_o |=> valid_o[$past(fill_set_o)]);

  a_r8_dirty_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_o & ~valid_o) == '0);

  a_r9_clr_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && line_clr_i |=> (($past(valid_o) & ~valid_o) == '0));

  a_r7_ready_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready_o && busy_o |-> fill_wr_o);

  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    miss_done_o |=> !miss_done_o);
endmodule

bind lfill_line_ctrl lfill_line_ctrl_chk #(.N_SETS(N_SETS), .LENW(LENW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .miss_ready_o (miss_ready_o),
  .miss_done_o  (miss_done_o),
  .rq_valid_o   (rq_valid_o),
  .rq_ready_i   (rq_ready_i),
  .rq_set_o     (rq_set_o),
  .rq_len_o     (rq_len_o),
  .fill_wr_o    (fill_wr_o),
  .fill_set_o   (fill_set_o),
  .line_clr_i   (line_clr_i),
  .valid_o      (valid_o),
  .dirty_o      (dirty_o),
  .busy_o       (busy_o)
);

// File: tb/lfill_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module lfill_line_ctrl_tb_top;
  localparam int NS = 16;
  localparam int DW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          miss_valid = 0, miss_pf = 0, rq_ready = 0, rs_valid = 0;
  logic          wr_hit = 0, line_clr = 0;
  logic [3:0]    miss_set = 0, wr_set = 0;
  logic [1:0]    miss_region = 0;
  logic [7:0]    cfg_burst = 8'b11_10_01_00;  // region r uses code r
  logic [DW-1:0] rs_data = '0;

  logic          miss_ready_o, miss_done_o, rq_valid_o, rs_ready_o, fill_wr_o, busy_o;
  logic [3:0]    rq_set_o, fill_set_o;
  logic [2:0]    rq_len_o;
  logic [DW-1:0] fill_data_o;
  logic [NS-1:0] valid_o, dirty_o;

  lfill_line_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .miss_valid_i(miss_valid), .miss_ready_o(miss_ready_o),
    .miss_set_i(miss_set), .miss_region_i(miss_region), .miss_pf_i(miss_pf),
    .miss_done_o(miss_done_o), .cfg_burst_i(cfg_burst),
    .rq_valid_o(rq_valid_o), .rq_ready_i(rq_ready), .rq_set_o(rq_set_o), .rq_len_o(rq_len_o),
    .rs_valid_i(rs_valid), .rs_ready_o(rs_ready_o), .rs_data_i(rs_data),
    .fill_wr_o(fill_wr_o), .fill_set_o(fill_set_o), .fill_data_o(fill_data_o),
    .wr_hit_i(wr_hit), .wr_set_i(wr_set), .line_clr_i(line_clr),
    .valid_o(valid_o), .dirty_o(dirty_o), .busy_o(busy_o)
  );

  int n_chk = 0, n_err = 0, done_cnt = 0, cyc = 0;
  logic [NS-1:0] ev = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && miss_done_o) done_cnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  function automatic logic [DW-1:0] pat(input int idx);
    return {16{8'(idx * 29 + 7)}};
  endfunction

  function automatic int exp_beats(input int start, input int code);
    int b = 0;
    while (start + b < NS && b < (1 << code) && !ev[start + b]) b++;
    return b;
  endfunction

  function automatic int next_inv(input int from);
    for (int i = from; i < NS; i++) if (!ev[i]) return i;
    return NS;
  endfunction

  task automatic do_miss(input int s, input int rg, input bit pf);
    bit acc = 0;
    @(negedge clk);
    miss_valid = 1; miss_set = 4'(s); miss_region = 2'(rg); miss_pf = pf;
    while (!acc) begin
      #0.5 acc = miss_ready_o;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
    @(negedge clk);
    miss_valid = 0;
  endtask

  task automatic wait_rq(input int start, input int beats);
    int t = 0;
    while (!rq_valid_o && t < 40) begin @(negedge clk); t++; end
    chk(rq_valid_o, "R2 request issued", rq_valid_o, 1);
    chk(rq_set_o == 4'(start), "R2/R3/R5 request start set", rq_set_o, start);
    chk(rq_len_o == 3'(beats - 1), "R2/R3 request length", rq_len_o, beats - 1);
    @(posedge clk); @(negedge clk);
    chk(rq_valid_o && rq_set_o == 4'(start) && rq_len_o == 3'(beats - 1),
        "R10 request held while not ready", {rq_valid_o, rq_set_o}, {1'b1, 4'(start)});
    rq_ready = 1;
    @(posedge clk); @(negedge clk);
    rq_ready = 0;
  endtask

  task automatic give_beat(input int idx, input int crit);
    rs_valid = 1; rs_data = pat(idx);
    #0.5;
    chk(rs_ready_o && fill_wr_o, "R6 beat accepted", {rs_ready_o, fill_wr_o}, 2'b11);
    chk(fill_set_o == 4'(idx), "R6 fill set order", fill_set_o, idx);
    chk(fill_data_o == pat(idx), "R6 fill data", fill_data_o[7:0], pat(idx) & 8'hff);
    @(posedge clk); @(negedge clk);
    rs_valid = 0;
    ev[idx] = 1'b1;
    if (idx == crit)
      chk(miss_done_o && valid_o[idx], "R4 done with set valid", {miss_done_o, valid_o[idx]}, 2'b11);
  endtask

  task automatic settle_check(input int d0, input string tag);
    repeat (4) @(negedge clk);
    chk(!busy_o && !rq_valid_o, {tag, " idle after fill"}, {busy_o, rq_valid_o}, 0);
    chk(valid_o == ev, {tag, " valid flags"}, valid_o, ev);
    chk(done_cnt == d0 + 1, "R4 single done pulse", done_cnt - d0, 1);
  endtask

  task automatic serve(input int ms, input int code, input bit pf);
    int s = ms, start, beats, d0;
    bit crit = 1;
    d0 = done_cnt;
    do_miss(ms, code, pf);
    if (ev[ms]) begin crit = 0; s = ms + 1; end
    while (crit || pf) begin
      start = crit ? s : next_inv(s);
      if (start >= NS) break;
      beats = exp_beats(start, code);
      wait_rq(start, beats);
      for (int b = 0; b < beats; b++) give_beat(start + b, crit ? ms : -1);
      s = start + beats;
      crit = 0;
    end
    settle_check(d0, "R5");
  endtask

  task automatic clear_line();
    @(negedge clk); line_clr = 1;
    @(posedge clk); @(negedge clk); line_clr = 0;
    ev = '0;
    chk(valid_o == '0 && dirty_o == '0, "R9 clear while idle", {valid_o, dirty_o}, 0);
  endtask

  task automatic write_hit(input int s);
    @(negedge clk); wr_hit = 1; wr_set = 4'(s);
    @(posedge clk); @(negedge clk); wr_hit = 0;
  endtask

  initial begin
    int d0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(valid_o == '0 && dirty_o == '0, "R1 flags clear", {valid_o, dirty_o}, 0);
    chk(!busy_o && !rq_valid_o && miss_ready_o, "R1 idle outputs",
        {busy_o, rq_valid_o, miss_ready_o}, 3'b001);
    rst_n = 1;

    // Sweep: every code, every missed set, prefetch off and on
    for (int code = 0; code < 4; code++)
      for (int ms = 0; ms < NS; ms++)
        for (int pf = 0; pf < 2; pf++) begin
          clear_line();
          serve(ms, code, pf[0]);
        end

    // R3/R5: partly filled line, clip at valid sets and skip them
    clear_line();
    serve(6, 0, 0);
    serve(10, 0, 0);
    serve(4, 3, 1);
    chk(valid_o == 16'hFFF0 | 16'h0000, "R5 prefetch filled to end", valid_o, 16'hFFF0);
    // R4: miss on a present set
    serve(6, 2, 0);

    // R8 dirty marking
    write_hit(6);
    chk(dirty_o == 16'h0040, "R8 dirty only written set", dirty_o, 16'h0040);
    clear_line();
    write_hit(3);
    chk(dirty_o == '0, "R8 write to invalid set ignored", dirty_o, 0);
    serve(3, 0, 0);
    write_hit(3);
    chk(dirty_o == 16'h0008, "R8 dirty after fill", dirty_o, 16'h0008);

    // R7/R9: preempt prefetch at a burst boundary, clear ignored while busy
    clear_line();
    d0 = done_cnt;
    do_miss(0, 1, 1);
    wait_rq(0, 2);
    give_beat(0, 0);
    give_beat(1, -1);
    wait_rq(2, 2);
    give_beat(2, -1);
    line_clr = 1;
    miss_valid = 1; miss_set = 4'd12; miss_region = 2'd0; miss_pf = 0;
    #0.5;
    chk(!miss_ready_o, "R7 no accept mid-burst", miss_ready_o, 0);
    @(posedge clk); @(negedge clk);
    line_clr = 0;
    chk(valid_o[2:0] == 3'b111, "R9 clear ignored while busy", valid_o[2:0], 3'b111);
    rs_valid = 1; rs_data = pat(3);
    #0.5;
    chk(miss_ready_o, "R7 accept on last beat", miss_ready_o, 1);
    @(posedge clk); @(negedge clk);
    rs_valid = 0; miss_valid = 0;
    ev[3] = 1'b1;
    wait_rq(12, 1);
    give_beat(12, 12);
    repeat (4) @(negedge clk);
    chk(valid_o == 16'h100F, "R7 received sets kept, prefetch dropped", valid_o, 16'h100F);
    chk(!busy_o, "R7 idle after preempting miss", busy_o, 0);
    chk(done_cnt == d0 + 2, "R4 one done per miss", done_cnt - d0, 2);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule